// File: doc/BRIEF.md
# Event trace packetizer

This block watches a 128-line internal event bus and a program-counter value and turns selected activity into trace frames. Eight trace slots each pick one event line by a 7-bit event number. In event-time mode a 16-bit frame records the 8-bit slot snapshot and how many cycles have passed since the previous frame. In event-PC mode a full-word frame records the snapshot together with the program counter, on each cycle where some slot is active.

Frames are packed into 32-bit words that no frame ever straddles. The words are buffered and leave on a 32-bit AXI4-Stream output in fixed packets of one header word and seven data words. Tracing is armed and disarmed by two programmable event numbers. When tracing stops, the partial packet is completed with filler and sent. When the output is stalled long enough that the buffer fills, new words are dropped and a sticky flag is raised.

Top module: `trace_packetizer`

## Requirements
- R1: While idle, a high level on the bus line numbered by `start_ev_i` starts tracing from the next cycle. While tracing, a high level on the line numbered by `stop_ev_i` ends tracing, and that cycle produces no frame. Selected events seen while idle produce nothing.
- R2: In event-time mode (`mode_pc_i`=0), a 16-bit frame {snapshot[15:8], count[7:0]} is produced on the first traced cycle and on every cycle whose snapshot differs from the previous cycle. The count is the number of traced cycles since the previous frame, and the first frame carries count 1.
- R3: In event-time mode, when 255 cycles have passed since the last frame without a change, a frame is emitted with count 255 and the count restarts.
- R4: In event-PC mode (`mode_pc_i`=1), every traced cycle with a nonzero snapshot produces the word {snapshot[31:24], pc[23:0]}. Cycles with an all-zero snapshot produce nothing.
- R5: In event-time mode, the older of two frames sits in data bits [31:16] and the newer in [15:0]. The filler frame is 16'h0000, and a padding word is all zeros.
- R6: Each packet is a header beat followed by seven data beats, with TLAST only on the seventh data beat. The header holds the stream ID in bits [4:0] and zeros in bits [30:5], and bit 31 makes the number of ones in the word odd.
- R7: On stop, a half-filled word is completed with a filler frame and the packet is padded with zero words to seven data words. A stop with no pending data sends no packet.
- R8: A completed word that finds the buffer full is dropped and `overflow_o` is set until reset. Packets stay eight beats long.
- R9: Snapshot bit k follows the bus line numbered by slot field k of `slot_ev_i` (bits 7k+6..7k).
- R10: During and right after reset, `m_tvalid_o` and `overflow_o` are low.
- R11: While `m_tvalid_o` is high and `m_tready_i` is low, `m_tvalid_o`, `m_tdata_o` and `m_tlast_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_bus_i | input | 128 | Internal event lines, indexed by event number |
| pc_i | input | 24 | Program counter value |
| mode_pc_i | input | 1 | 0: event-time mode, 1: event-PC mode |
| slot_ev_i | input | 56 | Eight 7-bit event numbers, slot k in bits 7k+6..7k |
| start_ev_i | input | 7 | Event number that starts tracing |
| stop_ev_i | input | 7 | Event number that stops tracing |
| stream_id_i | input | 5 | Stream ID placed in each header |
| m_tdata_o | output | 32 | Stream data |
| m_tvalid_o | output | 1 | Stream valid |
| m_tready_i | input | 1 | Stream ready |
| m_tlast_o | output | 1 | Last beat of a packet |
| overflow_o | output | 1 | Sticky flag set when words are dropped |

## Verification
The assertions assume that mode, slot numbers, trigger numbers and stream ID change only while the block is idle with its buffer drained. They also assume that the sink follows stream rules, so ready may drop at any time. The stimulus changes configuration only after waiting for every expected word to leave. It keeps the start and stop lines apart from the slot lines, and it varies ready at random only in phases where the frame rate stays below what the output can carry, so drops happen only in the deliberate overflow phase.

// File: rtl/trace_pkt_pkg.sv
package trace_pkt_pkg;
  parameter int WORD_W = 32;
  parameter int SID_W  = 5;

  typedef enum logic [1:0] {TS_IDLE, TS_RUN, TS_FLUSH} trc_state_e;

  function automatic logic [WORD_W-1:0] make_header(input logic [SID_W-1:0] id);
    logic [WORD_W-1:0] h;
    h = '0;
    h[SID_W-1:0] = id;
    h[WORD_W-1]  = ~(^id);
    return h;
  endfunction
endpackage

// File: rtl/trace_ev_select.sv
module trace_ev_select #(
  parameter int SLOTS = 8,
  parameter int ID_W  = 7
) (
  input  logic [(2**ID_W)-1:0]  bus_i,
  input  logic [SLOTS*ID_W-1:0] sel_i,
  output logic [SLOTS-1:0]      snap_o
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign snap_o[k] = bus_i[sel_i[k*ID_W +: ID_W]];
  end
endmodule

// File: rtl/trace_word_fifo.sv
module trace_word_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wd_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rd_o,
  output logic             full_o,
  output logic [AW:0]      level_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [AW:0]      lvl_q;

  assign full_o  = (lvl_q == (AW+1)'(DEPTH));
  assign level_o = lvl_q;
  assign rd_o    = mem[rp_q];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[wp_q] <= wd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (wr_i) wp_q <= wp_q + AW'(1);
      if (rd_i) rp_q <= rp_q + AW'(1);
      lvl_q <= lvl_q + (AW+1)'(wr_i) - (AW+1)'(rd_i);
    end
  end

  assert_no_wr_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !full_o);
  assert_no_rd_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> (lvl_q != '0));
endmodule

// File: rtl/trace_framer.sv
module trace_framer
  import trace_pkt_pkg::*;
#(
  parameter int SLOTS    = 8,
  parameter int PKT_DATA = 7,
  localparam int FRAME_W = 2*SLOTS,
  localparam int CNT_W   = FRAME_W - SLOTS,
  localparam int PC_W    = WORD_W - SLOTS,
  localparam int WC_W    = $clog2(PKT_DATA),
  localparam int CNT_LAST = (2**CNT_W) - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_pc_i,
  input  logic              start_hit_i,
  input  logic              stop_hit_i,
  input  logic [SLOTS-1:0]  snap_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              full_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o,
  output logic              overflow_o
);
  trc_state_e         state_q;
  logic               first_q, half_v_q, ovf_q;
  logic [SLOTS-1:0]   prev_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] half_q;
  logic [WC_W-1:0]    wc_q;

  logic               time_hit, word_v, drop;
  logic [FRAME_W-1:0] t_frame;
  logic [WORD_W-1:0]  word_d;

  always_comb begin
    time_hit = first_q || (snap_i != prev_q) || (cnt_q == CNT_W'(CNT_LAST));
    t_frame  = {snap_i, cnt_q + CNT_W'(1)};
    word_v   = 1'b0;
    word_d   = '0;
    unique case (state_q)
      TS_RUN: if (!stop_hit_i) begin
        if (mode_pc_i) begin
          word_v = |snap_i;
          word_d = {snap_i, pc_i};
        end else if (time_hit && half_v_q) begin
          word_v = 1'b1;
          word_d = {half_q, t_frame};
        end
      end
      TS_FLUSH: begin
        // complete a half word with filler, then pad out the packet
        word_v = half_v_q || (wc_q != '0);
        word_d = {half_q & {FRAME_W{half_v_q}}, {FRAME_W{1'b0}}};
      end
      default: ;
    endcase
  end

  assign push_o     = word_v && !full_i;
  assign drop       = word_v && full_i && (state_q == TS_RUN);
  assign word_o     = word_d;
  assign overflow_o = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= TS_IDLE;
      first_q  <= 1'b0;
      half_v_q <= 1'b0;
      ovf_q    <= 1'b0;
      prev_q   <= '0;
      cnt_q    <= '0;
      half_q   <= '0;
      wc_q     <= '0;
    end else begin
      if (push_o) wc_q <= (wc_q == WC_W'(PKT_DATA-1)) ? '0 : wc_q + WC_W'(1);
      if (drop) ovf_q <= 1'b1;
      unique case (state_q)
        TS_IDLE: if (start_hit_i) begin
          state_q  <= TS_RUN;
          first_q  <= 1'b1;
          cnt_q    <= '0;
          half_v_q <= 1'b0;
        end
        TS_RUN: if (stop_hit_i) begin
          state_q <= TS_FLUSH;
        end else begin
          prev_q  <= snap_i;
          first_q <= 1'b0;
          if (!mode_pc_i) begin
            if (time_hit) begin
              cnt_q <= '0;
              if (half_v_q) half_v_q <= 1'b0;
              else begin
                half_q   <= t_frame;
                half_v_q <= 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        TS_FLUSH: begin
          if (push_o && half_v_q) half_v_q <= 1'b0;
          if (!half_v_q && (wc_q == '0)) state_q <= TS_IDLE;
        end
        default: state_q <= TS_IDLE;
      endcase
    end
  end

  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  assert_time_count_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && !mode_pc_i && state_q == TS_RUN) |->
      (word_o[CNT_W-1:0] != '0) && (word_o[FRAME_W +: CNT_W] != '0));
  assert_pc_frame_active_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && mode_pc_i && state_q == TS_RUN) |-> (word_o[WORD_W-1 -: SLOTS] != '0));
  assert_idle_no_push_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TS_IDLE) |-> !push_o);
endmodule

// File: rtl/trace_pkt_out.sv
module trace_pkt_out
  import trace_pkt_pkg::*;
#(
  parameter int PKT_DATA = 7,
  parameter int LVL_W    = 5,
  localparam int IDX_W   = $clog2(PKT_DATA)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SID_W-1:0]  stream_id_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [WORD_W-1:0] head_i,
  output logic              pop_o,
  output logic [WORD_W-1:0] tdata_o,
  output logic              tvalid_o,
  input  logic              tready_i,
  output logic              tlast_o
);
  logic             data_q;
  logic [IDX_W-1:0] idx_q;

  // header goes out only once a whole packet of data is buffered
  assign tvalid_o = data_q || (level_i >= LVL_W'(PKT_DATA));
  assign tdata_o  = data_q ? head_i : make_header(stream_id_i);
  assign tlast_o  = data_q && (idx_q == IDX_W'(PKT_DATA-1));
  assign pop_o    = data_q && tready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= 1'b0;
      idx_q  <= '0;
    end else if (tvalid_o && tready_i) begin
      if (!data_q) begin
        data_q <= 1'b1;
        idx_q  <= '0;
      end else if (tlast_o) begin
        data_q <= 1'b0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  assert_hold_on_stall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tvalid_o && !tready_i) |=> tvalid_o && $stable(tdata_o) && $stable(tlast_o));
  assert_last_then_header_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tvalid_o && tready_i && tlast_o) |=> !tlast_o);
endmodule

// File: rtl/trace_packetizer.sv
module trace_packetizer
  import trace_pkt_pkg::*;
#(
  parameter int SLOTS      = 8,
  parameter int EV_ID_W    = 7,
  parameter int PKT_DATA   = 7,
  parameter int FIFO_DEPTH = 16,
  localparam int EV_BUS_W  = 2**EV_ID_W,
  localparam int PC_W      = WORD_W - SLOTS,
  localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [EV_BUS_W-1:0]     ev_bus_i,
  input  logic [PC_W-1:0]         pc_i,
  input  logic                    mode_pc_i,
  input  logic [SLOTS*EV_ID_W-1:0] slot_ev_i,
  input  logic [EV_ID_W-1:0]      start_ev_i,
  input  logic [EV_ID_W-1:0]      stop_ev_i,
  input  logic [SID_W-1:0]        stream_id_i,
  output logic [WORD_W-1:0]       m_tdata_o,
  output logic                    m_tvalid_o,
  input  logic                    m_tready_i,
  output logic                    m_tlast_o,
  output logic                    overflow_o
);
  logic [SLOTS-1:0]  snap;
  logic              push, pop, full;
  logic [WORD_W-1:0] word, head;
  logic [LVL_W-1:0]  level;

  trace_ev_select #(.SLOTS(SLOTS), .ID_W(EV_ID_W)) u_sel (
    .bus_i (ev_bus_i),
    .sel_i (slot_ev_i),
    .snap_o(snap)
  );

  trace_framer #(.SLOTS(SLOTS), .PKT_DATA(PKT_DATA)) u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_pc_i  (mode_pc_i),
    .start_hit_i(ev_bus_i[start_ev_i]),
    .stop_hit_i (ev_bus_i[stop_ev_i]),
    .snap_i     (snap),
    .pc_i       (pc_i),
    .full_i     (full),
    .push_o     (push),
    .word_o     (word),
    .overflow_o (overflow_o)
  );

  trace_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (push),
    .wd_i   (word),
    .rd_i   (pop),
    .rd_o   (head),
    .full_o (full),
    .level_o(level)
  );

  trace_pkt_out #(.PKT_DATA(PKT_DATA), .LVL_W(LVL_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stream_id_i(stream_id_i),
    .level_i    (level),
    .head_i     (head),
    .pop_o      (pop),
    .tdata_o    (m_tdata_o),
    .tvalid_o   (m_tvalid_o),
    .tready_i   (m_tready_i),
    .tlast_o    (m_tlast_o)
  );
endmodule

// File: tb/trace_packetizer_bench.sv
module trace_packetizer_bench;
  localparam int SLOTS = 8;
  localparam int IDW   = 7;
  localparam int BUSW  = 128;
  localparam int PCW   = 24;
  localparam logic [4:0] SID = 5'h05;
  localparam int START_N = 100;
  localparam int STOP_N  = 101;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                  rst_ni;
  logic [BUSW-1:0]       ev_bus;
  logic [PCW-1:0]        pc;
  logic                  mode_pc;
  logic [SLOTS*IDW-1:0]  slot_ev;
  logic [31:0]           tdata;
  logic                  tvalid, tready, tlast, ovf;

  trace_packetizer u_trace_packetizer (
    .clk_i(clk), .rst_ni(rst_ni), .ev_bus_i(ev_bus), .pc_i(pc), .mode_pc_i(mode_pc),
    .slot_ev_i(slot_ev), .start_ev_i(7'(START_N)), .stop_ev_i(7'(STOP_N)),
    .stream_id_i(SID), .m_tdata_o(tdata), .m_tvalid_o(tvalid), .m_tready_i(tready),
    .m_tlast_o(tlast), .overflow_o(ovf)
  );

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R2";

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model state
  logic [31:0] exp_q[$];
  bit          m_run, m_first, m_hv;
  logic [7:0]  m_prev;
  logic [15:0] m_half;
  int          m_cnt, m_wc, m_limit = -1, m_acc = 0;
  int          rdy_mode = 0;
  int          beats = 0, mon_idx = 0;

  function automatic void m_push(input logic [31:0] w, input bit flush);
    if (!flush && m_limit >= 0 && m_acc >= m_limit) return;
    exp_q.push_back(w);
    m_acc++;
    m_wc = (m_wc + 1) % 7;
  endfunction

  task automatic cyc(input logic [7:0] snap, input bit start, input bit stop, input logic [23:0] pcv);
    logic [15:0] fr;
    @(negedge clk);
    ev_bus = '0;
    for (int k = 0; k < SLOTS; k++) ev_bus[20 + k*5] = snap[k];
    ev_bus[START_N] = start;
    ev_bus[STOP_N]  = stop;
    pc = pcv;
    tready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (($urandom % 4) != 0) : 1'b0;
    if (!m_run) begin
      if (start) begin m_run = 1; m_first = 1; m_cnt = 0; m_hv = 0; end
    end else if (stop) begin
      if (m_hv) begin m_push({m_half, 16'h0000}, 1); m_hv = 0; end
      while (m_wc != 0) m_push(32'h0, 1);
      m_run = 0;
    end else if (mode_pc) begin
      if (snap != 0) m_push({snap, pcv}, 0);
      m_prev = snap; m_first = 0;
    end else begin
      if (m_first || snap != m_prev || m_cnt == 254) begin
        fr = {snap, 8'(m_cnt + 1)};
        m_cnt = 0;
        if (!m_hv) begin m_half = fr; m_hv = 1; end
        else begin m_push({m_half, fr}, 0); m_hv = 0; end
      end else m_cnt++;
      m_prev = snap; m_first = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(8'h00, 0, 0, 24'h0);
  endtask

  // monitor: sample mid-cycle, transfer happens at the following rising edge
  always @(negedge clk) begin
    #2;
    if (rst_ni && tvalid && tready) begin
      beats++;
      if (mon_idx == 0) begin
        chk(tdata == {~(^SID), 26'h0, SID} && !tlast, "R6 header", tdata, {~(^SID), 26'h0, SID});
      end else if (exp_q.size() == 0) begin
        chk(0, {cur_tag, " unexpected data"}, tdata, 32'h0);
      end else begin
        logic [31:0] w;
        w = exp_q.pop_front();
        chk(tdata == w, {cur_tag, " data"}, tdata, w);
        chk(tlast == (mon_idx == 7), "R6 tlast", {31'h0, tlast}, {31'h0, mon_idx == 7});
      end
      mon_idx = (mon_idx + 1) % 8;
    end
  end

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int b0;
    rst_ni = 0; ev_bus = '0; pc = '0; mode_pc = 0; tready = 1;
    for (int k = 0; k < SLOTS; k++) slot_ev[k*IDW +: IDW] = 7'(20 + k*5);
    repeat (3) @(negedge clk);
    chk(!tvalid && !ovf, "R10 in reset", {30'h0, tvalid, ovf}, 32'h0);
    @(negedge clk); rst_ni = 1;
    idle(2);
    chk(!tvalid && !ovf, "R10 after reset", {30'h0, tvalid, ovf}, 32'h0);

    // R1: selected events while idle are ignored
    b0 = beats; cur_tag = "R1";
    for (int i = 0; i < 12; i++) cyc(8'hFF, 0, 0, 24'h0);
    idle(20);
    chk(beats == b0 && exp_q.size() == 0, "R1 idle ignored", beats - b0, 0);

    // R2/R5/R9: event-time mode with walking slots
    cur_tag = "R2/R5/R9"; mode_pc = 0;
    cyc(8'h00, 1, 0, 0);
    cyc(8'h01, 0, 0, 0); cyc(8'h01, 0, 0, 0); cyc(8'h01, 0, 0, 0);
    cyc(8'h81, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(8'h00, 0, 0, 0);
    for (int k = 0; k < 8; k++) begin cyc(8'h01 << k, 0, 0, 0); cyc(8'h01 << k, 0, 0, 0); end
    cyc(8'h3C, 0, 1, 0);
    idle(40);
    chk(exp_q.size() == 0, "R7 time flush drained", exp_q.size(), 0);

    // R3: saturating count
    cur_tag = "R3";
    cyc(8'h00, 1, 0, 0);
    for (int i = 0; i < 600; i++) cyc(8'h5A, 0, 0, 0);
    cyc(8'h00, 0, 1, 0);
    idle(40);
    chk(exp_q.size() == 0, "R3 drained", exp_q.size(), 0);

    // R4/R11: event-PC mode under random ready
    cur_tag = "R4/R11"; mode_pc = 1; rdy_mode = 1;
    cyc(8'h00, 1, 0, 0);
    for (int i = 0; i < 40; i++)
      cyc((i % 2 == 0) ? 8'(($urandom % 255) + 1) : 8'h00, 0, 0, 24'(i*37 + 24'h100));
    cyc(8'h11, 0, 1, 24'hABCDEF);
    idle(120);
    rdy_mode = 0; idle(20);
    chk(exp_q.size() == 0, "R4 drained", exp_q.size(), 0);
    chk(!ovf, "R8 no overflow without excess", {31'h0, ovf}, 0);

    // R7: stop with nothing pending sends no packet
    cur_tag = "R7"; b0 = beats;
    cyc(8'h00, 1, 0, 0);
    for (int i = 0; i < 5; i++) cyc(8'h00, 0, 0, 24'h55);
    cyc(8'h00, 0, 1, 0);
    idle(30);
    chk(beats == b0, "R7 empty stop", beats - b0, 0);

    // R8: overflow under held backpressure
    cur_tag = "R8"; rdy_mode = 2; m_limit = 16; m_acc = 0;
    cyc(8'h00, 1, 0, 0);
    for (int i = 0; i < 30; i++) cyc(8'h0F, 0, 0, 24'(i + 1));
    cyc(8'h00, 0, 1, 0);
    idle(5);
    chk(ovf, "R8 overflow set", {31'h0, ovf}, 1);
    chk(tvalid, "R11 header held under stall", {31'h0, tvalid}, 1);
    m_limit = -1; rdy_mode = 0;
    idle(60);
    chk(exp_q.size() == 0, "R8 drained whole packets", exp_q.size(), 0);
    chk(ovf, "R8 overflow sticky", {31'h0, ovf}, 1);
    chk(mon_idx == 0, "R6 packet boundary", mon_idx, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule